// File: doc/BRIEF.md
# Two-Channel Bus-Master Disk DMA Register Bank

This block is the host-visible register bank of a two-channel bus-master disk controller. It decodes a 16-byte I/O window, 8 bytes per channel. Each channel has a command byte, a status byte, a timing byte and a 32-bit pointer to its descriptor table. A mode byte is shared by both channels. It records each channel's drive interrupt level and lets software block either channel. From that byte the block builds a single merged interrupt line.

The host reaches the bank through 32-bit word accesses with byte enables. The DMA engine gets per-channel start and direction controls and the descriptor pointers, and it reports completion with a one-cycle done pulse. Turning the start bit off does not abort a running transfer. The command change waits until the engine reports done, so storage never sees a partial transfer.

A parameter selects a reduced variant that has no mode byte and no timing bytes. In that variant those bytes read as all ones and ignore writes.

Top module: `bmide_regs`

## Requirements
- R1: Address map and layout:
  - `word_addr[1]` selects the channel and `word_addr[0]` selects the word.
  - Word 0 holds byte lane 0 = command, lane 1 = shared mode, lane 2 = status and lane 3 = timing.
  - Word 1 holds the 32-bit descriptor pointer, with lane b at bits 8b+7:8b.
- R2: A command write stores only bit 0 (start) and bit 3 (direction). The other command bits read as zero. `dma_start[c]` and `dma_dir[c]` reflect the stored bits.
- R3: A command write with start=1 while status bit 0 (active) is clear sets the active bit on the same edge.
- R4: A command write with start=0 while active leaves the command unchanged. The written value is applied on the edge where the done pulse ends the transfer.
- R5: A done pulse while active clears status bit 0 and sets status bit 2 (interrupt) on the same edge.
- R6: A status write does three things:
  - Bits 6:5 take the written value.
  - Bit 0 ignores the write.
  - Bits 2:1 clear only where a 1 is written.
  - Bits 7, 4 and 3 read as zero.
- R7: A mode write from either channel changes only bits 5:4, which are the block bits for channels 0 and 1. The result is visible from both channels.
- R8: Mode bits 3:2 follow `irq_req[1:0]` one clock later.
- R9: `irq` = (mode[2] AND NOT mode[4]) OR (mode[3] AND NOT mode[5]). It is combinational from the mode byte, so it updates right after the edge that changes that byte.
- R10: The timing byte reads back the last value written to it.
- R11: A pointer write updates only the enabled lanes. `prd_cur` takes the full new pointer on the same edge.
- R12: With SIMPLE=1, lanes 1 and 3 of word 0 read 0xFF and ignore writes, and `irq` is the OR of the registered request levels.
- R13: After reset, every command, status, mode, timing and pointer byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| word_addr | input | 2 | Word select: bit 1 channel, bit 0 word |
| byte_en | input | 4 | Write byte-lane enables |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Read data of the addressed word (combinational) |
| irq_req | input | 2 | Drive interrupt request level per channel |
| xfer_done | input | 2 | Engine completion pulse per channel |
| dma_start | output | 2 | Start control per channel |
| dma_dir | output | 2 | Direction control per channel |
| prd_base | output | 64 | Descriptor table pointer, channel 1 in the upper half |
| prd_cur | output | 64 | Current descriptor pointer, channel 1 in the upper half |
| irq | output | 1 | Merged interrupt |

## Verification
- **Timing of results.**
  - Every register write is visible on `rd_data` and on the control outputs after the edge that samples the strobe.
  - The mode bits track `irq_req` after one edge, and `irq` follows with no further delay.
  - A done pulse changes status and command on the single edge that samples it.
- **How the bench keeps to that timing.** The bench drives every input at the falling edge and holds a write for exactly one rising edge. It then samples at the next falling edge, which is one cycle after the stimulus for every result.
- **Cancel and completion.** A cancel is checked twice. First, while the transfer is still active, to confirm that the old command is held. Then in the cycle after the done pulse, to confirm that the command and the status have both changed.

// File: rtl/bmide_regs.sv
module bmide_regs #(
  parameter bit SIMPLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  word_addr,
  input  logic [3:0]  byte_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [1:0]  irq_req,
  input  logic [1:0]  xfer_done,
  output logic [1:0]  dma_start,
  output logic [1:0]  dma_dir,
  output logic [63:0] prd_base,
  output logic [63:0] prd_cur,
  output logic        irq
);
  localparam logic [7:0] CMD_MASK = 8'h09;

  logic [7:0]  cmd  [2];
  logic [7:0]  pend [2];
  logic [7:0]  sts  [2];
  logic [7:0]  tim  [2];
  logic [31:0] base [2];
  logic [31:0] cur  [2];
  logic [31:0] nb   [2];
  logic [1:0]  pend_v;
  logic [1:0]  ipend;
  logic [1:0]  blk;
  logic [1:0]  w0, w1, cancel;
  logic [7:0]  mode_rd;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      w0[c] = wr_en && (word_addr[1] == c[0]) && !word_addr[0];
      w1[c] = wr_en && (word_addr[1] == c[0]) &&  word_addr[0];
      cancel[c] = w0[c] && byte_en[0] && !wr_data[0] && sts[c][0];
      nb[c] = base[c];
      for (int b = 0; b < 4; b++)
        if (byte_en[b]) nb[c][8*b +: 8] = wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipend  <= '0;
      blk    <= '0;
      pend_v <= '0;
      for (int c = 0; c < 2; c++) begin
        cmd[c]  <= '0;
        pend[c] <= '0;
        sts[c]  <= '0;
        tim[c]  <= '0;
        base[c] <= '0;
        cur[c]  <= '0;
      end
    end else begin
      ipend <= irq_req;
      if (!SIMPLE && wr_en && !word_addr[0] && byte_en[1])
        blk <= wr_data[13:12];
      for (int c = 0; c < 2; c++) begin
        if (w0[c] && byte_en[0]) begin
          if (cancel[c]) begin
            pend[c]   <= wr_data[7:0] & CMD_MASK;
            pend_v[c] <= 1'b1;
          end else begin
            cmd[c]    <= wr_data[7:0] & CMD_MASK;
            pend_v[c] <= 1'b0;
            if (wr_data[0] && !sts[c][0]) sts[c][0] <= 1'b1;
          end
        end
        if (w0[c] && byte_en[2]) begin
          sts[c][6:5] <= wr_data[22:21];
          sts[c][2:1] <= sts[c][2:1] & ~wr_data[18:17];
        end
        if (!SIMPLE && w0[c] && byte_en[3])
          tim[c] <= wr_data[31:24];
        if (w1[c]) begin
          base[c] <= nb[c];
          cur[c]  <= nb[c];
        end
        if (xfer_done[c] && sts[c][0]) begin
          sts[c][0] <= 1'b0;
          sts[c][2] <= 1'b1;
          if (cancel[c]) begin
            cmd[c]    <= wr_data[7:0] & CMD_MASK;
            pend_v[c] <= 1'b0;
          end else if (pend_v[c]) begin
            cmd[c]    <= pend[c];
            pend_v[c] <= 1'b0;
          end
        end
      end
    end
  end

  assign mode_rd = SIMPLE ? 8'hFF : {2'b00, blk, ipend, 2'b00};

  always_comb begin
    if (word_addr[0])
      rd_data = base[word_addr[1]];
    else
      rd_data = {SIMPLE ? 8'hFF : tim[word_addr[1]], sts[word_addr[1]],
                 mode_rd, cmd[word_addr[1]]};
  end

  assign dma_start = {cmd[1][0], cmd[0][0]};
  assign dma_dir   = {cmd[1][3], cmd[0][3]};
  assign prd_base  = {base[1], base[0]};
  assign prd_cur   = {cur[1], cur[0]};
  assign irq       = (ipend[0] & ~blk[0]) | (ipend[1] & ~blk[1]);
endmodule

// File: rtl/bmide_regs_chk.sv
module bmide_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  word_addr,
  input logic [1:0]  irq_req,
  input logic [1:0]  xfer_done,
  input logic [1:0]  dma_start,
  input logic [63:0] prd_base,
  input logic [63:0] prd_cur,
  input logic        irq,
  input logic [1:0]  act,
  input logic [1:0]  intf
);
  // R5
  done_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done[0] && act[0]) |=> (!act[0] && intf[0]));
  // R5
  done_clears_act1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done[1] && act[1]) |=> (!act[1] && intf[1]));
  // R4
  start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && !xfer_done[0] && dma_start[0]) |=> dma_start[0]);
  // R4
  start_held1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1] && !xfer_done[1] && dma_start[1]) |=> dma_start[1]);
  // R9
  no_req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == 2'b00) |=> !irq);
  // R11
  cur_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_addr == 2'b01) |=> (prd_cur[31:0] == prd_base[31:0]));
  // R11
  cur_copy1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_addr == 2'b11) |=> (prd_cur[63:32] == prd_base[63:32]));
endmodule

bind bmide_regs bmide_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
  .irq_req(irq_req), .xfer_done(xfer_done), .dma_start(dma_start),
  .prd_base(prd_base), .prd_cur(prd_cur), .irq(irq),
  .act({sts[1][0], sts[0][0]}), .intf({sts[1][2], sts[0][2]})
);

// File: tb/bmide_regs_tb.sv
module bmide_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  word_addr = '0;
  logic [3:0]  byte_en = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  irq_req = '0;
  logic [1:0]  xfer_done = '0;
  logic [31:0] rd_data, rd_s;
  logic [1:0]  dma_start, dma_dir, start_s, dir_s;
  logic [63:0] prd_base, prd_cur, base_s, cur_s;
  logic        irq, irq_s;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bmide_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_req(irq_req), .xfer_done(xfer_done), .dma_start(dma_start),
    .dma_dir(dma_dir), .prd_base(prd_base), .prd_cur(prd_cur), .irq(irq));

  bmide_regs #(.SIMPLE(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_addr(word_addr),
    .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_s),
    .irq_req(irq_req), .xfer_done(xfer_done), .dma_start(start_s),
    .dma_dir(dir_s), .prd_base(base_s), .prd_cur(cur_s), .irq(irq_s));

  // {word_addr, byte_en, wr_data, expected read of the same word}
  localparam logic [69:0] VEC [9] = '{
    {2'd1, 4'hF, 32'h12345678, 32'h12345678},  // R11 full word
    {2'd1, 4'h4, 32'h00AB0000, 32'h12AB5678},  // R11 lane 2
    {2'd1, 4'h3, 32'h0000BEEF, 32'h12ABBEEF},  // R11 lanes 1:0
    {2'd3, 4'hF, 32'hCAFEF00D, 32'hCAFEF00D},  // R1 channel 1 pointer
    {2'd0, 4'h8, 32'h5A000000, 32'h5A000000},  // R10 timing
    {2'd0, 4'h2, 32'h0000FF00, 32'h5A003000},  // R7 only block bits
    {2'd0, 4'h4, 32'h00FF0000, 32'h5A603000},  // R6 status write
    {2'd0, 4'h1, 32'h000000F6, 32'h5A603000},  // R2 masked command
    {2'd2, 4'hF, 32'h00FFFF76, 32'h00603000}   // R7 shared mode, R2
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; word_addr = a; byte_en = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; byte_en = '0;
  endtask

  task automatic rd_at(input logic [1:0] a);
    word_addr = a;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd_at(a[1:0]);
      chk("R13 reset word", {32'h0, rd_data}, 64'h0);
    end
    chk("R13 reset ctl", {59'h0, dma_start, dma_dir, irq}, 64'h0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
      rd_at(VEC[i][69:68]);
      chk("R1/R2/R6/R7/R10/R11 table", {32'h0, rd_data}, {32'h0, VEC[i][31:0]});
    end
    chk("R11 cur copy", prd_cur, 64'hCAFEF00D_12ABBEEF);
    chk("R11 base", prd_base, 64'hCAFEF00D_12ABBEEF);
    rd_at(2'd0);
    chk("R12 simple word0", {32'h0, rd_s}, 64'hFF60FF00);

    wr(2'd0, 4'h1, 32'h00000009);
    rd_at(2'd0);
    chk("R3 start sets active", {32'h0, rd_data}, 64'h5A613009);
    chk("R2 start/dir", {60'h0, dma_start, dma_dir}, 64'h5);
    wr(2'd0, 4'h1, 32'h00000000);
    rd_at(2'd0);
    chk("R4 cancel held", {32'h0, rd_data}, 64'h5A613009);
    chk("R4 start held", {62'h0, dma_start}, 64'h1);
    @(negedge clk); xfer_done = 2'b01;
    @(negedge clk); xfer_done = 2'b00;
    rd_at(2'd0);
    chk("R5/R4 done edge", {32'h0, rd_data}, 64'h5A643000);
    chk("R4 start dropped", {62'h0, dma_start}, 64'h0);
    @(negedge clk); xfer_done = 2'b01;
    @(negedge clk); xfer_done = 2'b00;
    rd_at(2'd0);
    chk("R5 done ignored idle", {32'h0, rd_data}, 64'h5A643000);

    wr(2'd0, 4'h4, 32'h00600000);
    rd_at(2'd0);
    chk("R6 w0 keeps bit2", {32'h0, rd_data}, 64'h5A643000);
    wr(2'd0, 4'h4, 32'h00640000);
    rd_at(2'd0);
    chk("R6 w1c bit2", {32'h0, rd_data}, 64'h5A603000);
    wr(2'd0, 4'h4, 32'h00010000);
    rd_at(2'd0);
    chk("R6 bit0 ignored", {32'h0, rd_data}, 64'h5A003000);

    @(negedge clk); irq_req = 2'b10;
    @(negedge clk); rd_at(2'd0);
    chk("R8 mode follows", {56'h0, rd_data[15:8]}, 64'h38);
    chk("R9 blocked", {63'h0, irq}, 64'h0);
    chk("R12 simple irq", {63'h0, irq_s}, 64'h1);
    wr(2'd2, 4'h2, 32'h00001000);
    rd_at(2'd0);
    chk("R7 mode via ch1", {56'h0, rd_data[15:8]}, 64'h18);
    chk("R9 ch1 unblocked", {63'h0, irq}, 64'h1);
    @(negedge clk); irq_req = 2'b01;
    @(negedge clk); rd_at(2'd0);
    chk("R9 ch0 blocked", {63'h0, irq}, 64'h0);
    wr(2'd0, 4'h2, 32'h00000000);
    chk("R9 ch0 unblocked", {63'h0, irq}, 64'h1);
    @(negedge clk); irq_req = 2'b00;
    @(negedge clk); rd_at(2'd0);
    chk("R8/R9 cleared", {55'h0, rd_data[15:8], irq}, 64'h0);

    wr(2'd0, 4'hA, 32'h77003000);
    rd_at(2'd0);
    chk("R12 simple ignores", {32'h0, rd_s}, 64'hFF00FF00);
    rd_at(2'd2);
    chk("R10 ch1 timing", {56'h0, rd_data[31:24]}, 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule